// File: doc/BRIEF.md
# Nested Priority Vectored Interrupt Controller

This block collects up to 32 interrupt request lines, qualifies each one with its own trigger type and enable bit, picks the most urgent one, and drives a single interrupt line towards a processor. Software reaches it over a simple register bus with a select, a write flag, a word address, write data and combinational read data. Each source has a mode word that holds a 3-bit priority and a 2-bit trigger code, and a 32-bit vector word that software loads with any value, for example a handler address or a source number.

A read of the current-vector address does two things: it returns the vector of the winning source, and it acknowledges that source. The acknowledge clears the source's edge latch and pushes its priority onto an 8-entry level stack. While a level is on the stack, only a strictly higher priority can raise the interrupt line again. An end-of-interrupt write pops one level. When nothing can be granted, the read returns the spurious value held in a software register and the stack stays as it was. Enabling and disabling are done with write-one set and clear commands. A write-one clear command drops latched edges.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset the enable mask reads 0, `irq_out` is low, every mode word reads 0 (high level, priority 0), and a current-vector read returns the spurious register's reset value 0 and pushes nothing.
- R2: A write to the enable-set address (64+1) sets each mask bit whose data bit is 1. A write to the enable-clear address (64+2) clears each mask bit whose data bit is 1. Zero data bits leave their mask bits as they were. The mask reads back at address 64+3.
- R3: The mode word of source i is at address i, with priority in bits [2:0] and trigger code in bits [5:4]: 0 high level, 1 rising edge, 2 low level, 3 falling edge. The vector word of source i is at address 32+i, and the spurious value is at address 64+6. All of them read back as written.
- R4: Trigger codes 2 and 3 are accepted only for source 0 and for sources 24 to 31. A mode write to sources 1 to 23 that carries code 2 or 3 updates the priority and keeps the previous trigger code.
- R5: A level-triggered source is pending while its registered input sample is at the active level: 1 for code 0, 0 for code 2.
- R6: An edge-triggered source latches a pending flag on a 0-to-1 change (code 1) or a 1-to-0 change (code 3) of its registered input sample. The flag stays set after the input returns, and a write of 1 to that source's bit at the edge-clear address (64+4) clears it.
- R7: Among enabled pending sources, the highest priority wins (7 is the highest). On equal priority the lowest source number wins. A read at the current-vector address (64+0) returns the winner's vector word.
- R8: If no enabled pending source has a priority strictly above the stack top (with any priority allowed when the stack is empty), a current-vector read returns the spurious value and leaves the stack unchanged.
- R9: A current-vector read that returns a source's vector pushes that source's priority and clears its edge latch.
- R10: `irq_out` is high exactly when an enabled pending source has a priority strictly above the stack top, or when any enabled source is pending and the stack is empty. A write to the end-of-interrupt address (64+5) pops one level, and has no effect on an empty stack.
- R11: The stack holds up to 8 levels, and 8 end-of-interrupt writes always leave it empty.
- R12: A write of all ones to the enable-clear address, followed by a write of all ones to the edge-clear address, leaves the mask at 0, `irq_out` low and no latched edge, so that enabling everything again with idle inputs raises nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 7 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed word (combinational) |
| src_in | input | 32 | Raw interrupt request lines, one for each source |
| irq_out | output | 1 | Interrupt request towards the processor |

## Verification
Arbitration is driven four ways on level sources. A walking single bit ties each source number to its own vector. Pairs of sources with equal priority show whether the tie goes to the lower number. Pseudo-random dense and sparse request words test the priority ordering against a model computed in the bench, and an empty word yields the spurious vector. Edge sources are pulsed and then cleared or acknowledged, which tells a latch apart from a level. A ladder of rising priorities fills the stack to 8 and unwinds it again, which separates "strictly above" from "at or above" and shows that a lower request waits. The mode sweep writes all four trigger codes to every source, which exposes the internal-source restriction.

// File: rtl/nic_pkg.sv
`timescale 1ns/1ps
// nic_pkg: shared constants for the nested interrupt controller.
// Assumes: the trigger code is 2 bits, and control offsets are relative to
// the control window that follows the vector words.
package nic_pkg;
    localparam logic [1:0] TRIG_HIGH = 2'd0;
    localparam logic [1:0] TRIG_RISE = 2'd1;
    localparam logic [1:0] TRIG_LOW  = 2'd2;
    localparam logic [1:0] TRIG_FALL = 2'd3;

    // bit positions inside a mode word
    localparam int PRIO_LSB = 0;
    localparam int TRIG_LSB = 4;

    // offsets inside the control window
    localparam int OFS_CUR_VEC  = 0;
    localparam int OFS_EN_SET   = 1;
    localparam int OFS_EN_CLR   = 2;
    localparam int OFS_MASK     = 3;
    localparam int OFS_EDGE_CLR = 4;
    localparam int OFS_EOI      = 5;
    localparam int OFS_SPUR     = 6;

    // Low-active triggers are only legal on source 0 and on external lines.
    function automatic logic trig_legal(input int unsigned idx,
                                        input int unsigned ext_base,
                                        input logic [1:0]  code);
        return (code == TRIG_HIGH) || (code == TRIG_RISE) ||
               (idx == 0) || (idx >= ext_base);
    endfunction
endpackage

// File: rtl/nic_src_front.sv
`timescale 1ns/1ps
// nic_src_front: samples every request line, detects edges against the
// previous sample and holds an edge latch for each source. Its output is the
// pending state of each source, enable not yet applied.
// Assumes: src_in is already synchronous to clk; ack and edge_clr are
// one-cycle strobes; a new edge in the same cycle as a clear wins.
module nic_src_front
    import nic_pkg::*;
#(
    parameter int N_SRC = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [N_SRC-1:0]      src_in,
    input  logic [N_SRC-1:0][1:0] trig,
    input  logic [N_SRC-1:0]      edge_clr,
    input  logic [N_SRC-1:0]      ack,
    output logic [N_SRC-1:0]      pend
);
    logic [N_SRC-1:0] in_s;       // current registered sample
    logic [N_SRC-1:0] in_p;       // sample one cycle older
    logic [N_SRC-1:0] edge_q;     // latched edges
    logic [N_SRC-1:0] edge_set;
    logic [N_SRC-1:0] edge_nxt;

    // Register the raw lines and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_s <= '0;
            in_p <= '0;
        end else begin
            in_s <= src_in;
            in_p <= in_s;
        end
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        // Edge seen for this source under its current trigger code.
        assign edge_set[g] = ((trig[g] == TRIG_RISE) &&  in_s[g] && !in_p[g]) ||
                             ((trig[g] == TRIG_FALL) && !in_s[g] &&  in_p[g]);
        // A new edge overrides a clear or acknowledge in the same cycle.
        assign edge_nxt[g] = edge_set[g] ? 1'b1 :
                             ((edge_clr[g] || ack[g]) ? 1'b0 : edge_q[g]);
        // Level codes follow the sample; edge codes follow the latch.
        always_comb begin
            unique case (trig[g])
                TRIG_HIGH: pend[g] = in_s[g];
                TRIG_LOW:  pend[g] = !in_s[g];
                default:   pend[g] = edge_q[g];
            endcase
        end

        // R9: an acknowledge without a new edge leaves the latch empty
        a_r9_ack_clears_latch: assert property (@(posedge clk) disable iff (!rst_n)
            (ack[g] && !edge_set[g]) |=> !edge_q[g]);
        // R6: a latched edge survives until it is cleared or acknowledged
        a_r6_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
            (edge_q[g] && !ack[g] && !edge_clr[g]) |=> edge_q[g]);
        // R6: a detected edge is latched
        a_r6_edge_latched: assert property (@(posedge clk) disable iff (!rst_n)
            edge_set[g] |=> edge_q[g]);
    end

    // Update all edge latches.
    always_ff @(posedge clk) begin
        if (!rst_n) edge_q <= '0;
        else        edge_q <= edge_nxt;
    end
endmodule

// File: rtl/nic_arbiter.sv
`timescale 1ns/1ps
// nic_arbiter: finds the candidate with the highest priority. On equal
// priority the lowest index wins. Purely combinational.
// Assumes: cand already combines enable and pending.
module nic_arbiter #(
    parameter int N_SRC  = 32,
    parameter int PRIO_W = 3,
    localparam int IDX_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             cand,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio,
    output logic                         any,
    output logic [IDX_W-1:0]             win_idx,
    output logic [PRIO_W-1:0]            win_prio
);
    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        any      = 1'b0;
        win_idx  = '0;
        win_prio = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (cand[i] && (!any || prio[i] >= win_prio)) begin
                any      = 1'b1;
                win_idx  = IDX_W'(i);
                win_prio = prio[i];
            end
        end
    end
endmodule

// File: rtl/nic_level_stack.sv
`timescale 1ns/1ps
// nic_level_stack: LIFO of the priorities of acknowledged interrupts.
// Assumes: the caller pushes only priorities above the current top, so depth
// 2**PRIO_W never overflows; push and pop are never requested together (push
// wins if they are).
module nic_level_stack #(
    parameter int DEPTH  = 8,
    parameter int PRIO_W = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int SLOT_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_prio,
    input  logic              pop,
    output logic              empty,
    output logic [PRIO_W-1:0] top,
    output logic [CNT_W-1:0]  count
);
    logic [DEPTH-1:0][PRIO_W-1:0] slot;
    logic [SLOT_W-1:0]            top_ptr;

    assign empty   = (count == '0);
    assign top_ptr = SLOT_W'(count - CNT_W'(1));
    assign top     = empty ? '0 : slot[top_ptr];

    // Push stores at the count position; pop only moves the count back.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            slot  <= '0;
        end else if (push && count < CNT_W'(DEPTH)) begin
            slot[SLOT_W'(count)] <= push_prio;
            count                <= count + CNT_W'(1);
        end else if (pop && !empty) begin
            count <= count - CNT_W'(1);
        end
    end

    // R11: the level count never exceeds the depth
    a_r11_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH));
    // R10: a push always lands above the current top
    a_r10_push_above_top: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (empty || push_prio > top));
    // R10: one pop removes exactly one level
    a_r10_pop_one: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> count == $past(count) - CNT_W'(1));
    // R10: a pop on an empty stack leaves it empty
    a_r10_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty);
endmodule

// File: rtl/nest_irq_ctrl.sv
`timescale 1ns/1ps
// nest_irq_ctrl: vectored interrupt controller with nested priority levels.
// It holds the register file, decodes the bus, and ties together the source
// front end, the arbiter and the level stack.
// Assumes: N_SRC is a power of two and at most DATA_W; PRIO_W <= 4 so the
// priority and trigger fields do not overlap; ADDR_W covers 2*N_SRC+7 words;
// only one bus access per cycle.
module nest_irq_ctrl
    import nic_pkg::*;
#(
    parameter int N_SRC       = 32,
    parameter int EXT_BASE    = 24,
    parameter int PRIO_W      = 3,
    parameter int STACK_DEPTH = 8,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_SRC-1:0]  src_in,
    output logic              irq_out
);
    localparam int IDX_W = $clog2(N_SRC);
    localparam int CNT_W = $clog2(STACK_DEPTH + 1);
    localparam logic [ADDR_W-1:0] VEC_BASE  = ADDR_W'(N_SRC);
    localparam logic [ADDR_W-1:0] CTRL_BASE = ADDR_W'(2 * N_SRC);

    // register file
    logic [N_SRC-1:0][PRIO_W-1:0] src_prio;
    logic [N_SRC-1:0][1:0]        src_trig;
    logic [N_SRC-1:0][DATA_W-1:0] src_vec;
    logic [N_SRC-1:0]             en_mask;
    logic [DATA_W-1:0]            spur_val;

    // decode
    logic              wr_en, rd_en, in_mode, in_vec, in_ctrl;
    logic [ADDR_W-1:0] vec_off, ctrl_off;
    logic [IDX_W-1:0]  mode_idx, vec_idx;
    logic              wr_en_set, wr_en_clr, wr_edge_clr, wr_eoi, wr_spur, rd_cur;

    // datapath between the submodules
    logic [N_SRC-1:0]  pend, cand, ack_vec, edge_clr_vec;
    logic              any_cand, grant_ok;
    logic [IDX_W-1:0]  win_idx;
    logic [PRIO_W-1:0] win_prio, stk_top;
    logic              stk_empty, do_push;
    logic [CNT_W-1:0]  stk_count;

    // Split the address into mode, vector and control windows.
    assign wr_en    = bus_sel && bus_wr;
    assign rd_en    = bus_sel && !bus_wr;
    assign in_mode  = bus_addr < VEC_BASE;
    assign in_vec   = !in_mode && (bus_addr < CTRL_BASE);
    assign in_ctrl  = !in_mode && !in_vec;
    assign vec_off  = bus_addr - VEC_BASE;
    assign ctrl_off = bus_addr - CTRL_BASE;
    assign mode_idx = bus_addr[IDX_W-1:0];
    assign vec_idx  = vec_off[IDX_W-1:0];

    // Strobes for the control commands.
    assign wr_en_set   = wr_en && in_ctrl && (ctrl_off == ADDR_W'(OFS_EN_SET));
    assign wr_en_clr   = wr_en && in_ctrl && (ctrl_off == ADDR_W'(OFS_EN_CLR));
    assign wr_edge_clr = wr_en && in_ctrl && (ctrl_off == ADDR_W'(OFS_EDGE_CLR));
    assign wr_eoi      = wr_en && in_ctrl && (ctrl_off == ADDR_W'(OFS_EOI));
    assign wr_spur     = wr_en && in_ctrl && (ctrl_off == ADDR_W'(OFS_SPUR));
    assign rd_cur      = rd_en && in_ctrl && (ctrl_off == ADDR_W'(OFS_CUR_VEC));

    // Mode words; an illegal trigger code keeps the old one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_prio <= '0;
            for (int i = 0; i < N_SRC; i++) src_trig[i] <= TRIG_HIGH;
        end else if (wr_en && in_mode) begin
            src_prio[mode_idx] <= bus_wdata[PRIO_LSB +: PRIO_W];
            if (trig_legal(32'(mode_idx), EXT_BASE, bus_wdata[TRIG_LSB +: 2]))
                src_trig[mode_idx] <= bus_wdata[TRIG_LSB +: 2];
        end
    end

    // Vector words and the spurious value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_vec  <= '0;
            spur_val <= '0;
        end else begin
            if (wr_en && in_vec) src_vec[vec_idx] <= bus_wdata;
            if (wr_spur)         spur_val         <= bus_wdata;
        end
    end

    // Enable mask through write-one set and clear commands.
    always_ff @(posedge clk) begin
        if (!rst_n)         en_mask <= '0;
        else if (wr_en_set) en_mask <= en_mask | bus_wdata[N_SRC-1:0];
        else if (wr_en_clr) en_mask <= en_mask & ~bus_wdata[N_SRC-1:0];
    end

    // Command vectors for the front end.
    assign edge_clr_vec = wr_edge_clr ? bus_wdata[N_SRC-1:0] : '0;
    assign ack_vec      = do_push ? (N_SRC'(1) << win_idx) : '0;

    nic_src_front #(.N_SRC(N_SRC)) u_front (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_in   (src_in),
        .trig     (src_trig),
        .edge_clr (edge_clr_vec),
        .ack      (ack_vec),
        .pend     (pend)
    );

    assign cand = pend & en_mask;

    nic_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .cand     (cand),
        .prio     (src_prio),
        .any      (any_cand),
        .win_idx  (win_idx),
        .win_prio (win_prio)
    );

    // The winner may preempt only above the current level.
    assign grant_ok = any_cand && (stk_empty || win_prio > stk_top);
    assign do_push  = rd_cur && grant_ok;
    assign irq_out  = grant_ok;

    nic_level_stack #(.DEPTH(STACK_DEPTH), .PRIO_W(PRIO_W)) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (do_push),
        .push_prio (win_prio),
        .pop       (wr_eoi),
        .empty     (stk_empty),
        .top       (stk_top),
        .count     (stk_count)
    );

    // Read multiplexer over the three windows.
    always_comb begin
        bus_rdata = '0;
        if (in_mode) begin
            bus_rdata[PRIO_LSB +: PRIO_W] = src_prio[mode_idx];
            bus_rdata[TRIG_LSB +: 2]      = src_trig[mode_idx];
        end else if (in_vec) begin
            bus_rdata = src_vec[vec_idx];
        end else begin
            case (ctrl_off)
                ADDR_W'(OFS_CUR_VEC): bus_rdata = grant_ok ? src_vec[win_idx] : spur_val;
                ADDR_W'(OFS_MASK):    bus_rdata[N_SRC-1:0] = en_mask;
                ADDR_W'(OFS_SPUR):    bus_rdata = spur_val;
                default:              bus_rdata = '0;
            endcase
        end
    end

    // R2: set bits are visible in the mask one cycle after the write
    a_r2_set_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_set |=> (en_mask & $past(bus_wdata[N_SRC-1:0])) == $past(bus_wdata[N_SRC-1:0]));
    // R2: cleared bits are gone one cycle after the write
    a_r2_clr_visible: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_clr |=> (en_mask & $past(bus_wdata[N_SRC-1:0])) == '0);
    // R8: a spurious read leaves the stack depth unchanged
    a_r8_spur_no_push: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cur && !grant_ok) |=> stk_count == $past(stk_count));
    // R9: a granted read adds exactly one level
    a_r9_grant_push: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_cur && grant_ok) |=> stk_count == $past(stk_count) + CNT_W'(1));

    for (genvar g = 1; g < EXT_BASE && g < N_SRC; g++) begin : g_int_chk
        // R4: internal sources only ever hold high-level or rising codes
        a_r4_internal_trig: assert property (@(posedge clk) disable iff (!rst_n)
            (src_trig[g] == TRIG_HIGH) || (src_trig[g] == TRIG_RISE));
    end
endmodule

// File: tb/nest_irq_ctrl_test.sv
`timescale 1ns/1ps
// Self-checking bench: a behavioural model in plain integers is compared with
// the design through its bus and its interrupt line.
module nest_irq_ctrl_test;
    localparam int A_CUR = 64, A_ENS = 65, A_ENC = 66, A_MASK = 67;
    localparam int A_ECLR = 68, A_EOI = 69, A_SPUR = 70;
    localparam logic [31:0] SPUR = 32'h0000_05A5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_in = '0;
    logic        irq_out;

    int total = 0, bad = 0;
    bit done = 1'b0;

    // model state
    int          m_prio [32];
    int          m_trig [32];
    logic [31:0] m_en = '0;
    logic [31:0] m_latch = '0;
    int          stk [8];
    int          sc = 0;
    logic [31:0] m_spur = '0;

    always #2.5 clk = ~clk;

    nest_irq_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 7'(a); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 7'(a);
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    function automatic logic m_pend(int i);
        case (m_trig[i])
            0:       return src_in[i];
            2:       return !src_in[i];
            default: return m_latch[i];
        endcase
    endfunction

    // highest priority, lowest index first (ascending scan, strict compare)
    function automatic int m_win();
        int best = -1;
        for (int i = 0; i < 32; i++)
            if (m_en[i] && m_pend(i) && (best < 0 || m_prio[i] > m_prio[best])) best = i;
        return best;
    endfunction

    function automatic logic m_irq();
        int w = m_win();
        return (w >= 0) && (sc == 0 || m_prio[w] > stk[sc-1]);
    endfunction

    task automatic set_mode(input int i, input int t, input int p);
        wr(i, 32'((t << 4) | p));
        m_prio[i] = p;
        if (t < 2 || i == 0 || i >= 24) m_trig[i] = t;
    endtask

    task automatic check_irq(input string req);
        @(negedge clk);
        chk(req, 32'(irq_out), 32'(m_irq()));
    endtask

    task automatic do_ack(input string req);
        logic [31:0] d;
        int w;
        logic ok;
        w  = m_win();
        ok = m_irq();
        rd(A_CUR, d);
        chk(req, d, ok ? 32'h100 + 32'(w) : m_spur);
        if (ok) begin
            stk[sc] = m_prio[w];
            sc++;
            if (m_trig[w] == 1 || m_trig[w] == 3) m_latch[w] = 1'b0;
        end
    endtask

    task automatic do_eoi();
        wr(A_EOI, 32'h0);
        if (sc > 0) sc--;
    endtask

    // pulse lines high and back low; edge sources latch
    task automatic pulse(input logic [31:0] m);
        src_in = src_in | m;
        repeat (2) @(negedge clk);
        src_in = src_in & ~m;
        settle();
        for (int i = 0; i < 32; i++)
            if (m[i] && (m_trig[i] == 1 || m_trig[i] == 3)) m_latch[i] = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog R1-chain: actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [31:0] lf;
        for (int i = 0; i < 32; i++) begin m_prio[i] = 0; m_trig[i] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(A_MASK, d);   chk("R1 mask", d, 32'h0);
        check_irq("R1 irq");
        rd(5, d);        chk("R1 mode", d, 32'h0);
        do_ack("R1 spurious read");
        check_irq("R1 no push");

        // R3: vector words and spurious value
        for (int i = 0; i < 32; i++) wr(32 + i, 32'h100 + 32'(i));
        wr(A_SPUR, SPUR); m_spur = SPUR;
        rd(A_SPUR, d);   chk("R3 spur", d, SPUR);
        for (int i = 0; i < 32; i += 7) begin
            rd(32 + i, d); chk("R3 vector", d, 32'h100 + 32'(i));
        end

        // R3 / R4: every trigger code on every source
        for (int i = 0; i < 32; i++)
            for (int t = 0; t < 4; t++) begin
                set_mode(i, t, (i + t) % 8);
                rd(i, d);
                chk((i > 0 && i < 24) ? "R4 internal trig" : "R3 mode", d,
                    32'((m_trig[i] << 4) | m_prio[i]));
            end

        // R2: write-one set and clear
        wr(A_ENS, 32'hF0F0_1234); m_en = 32'hF0F0_1234;
        rd(A_MASK, d); chk("R2 set", d, m_en);
        wr(A_ENS, 32'h0);
        rd(A_MASK, d); chk("R2 zero set", d, m_en);
        wr(A_ENC, 32'h1000_0204); m_en = m_en & ~32'h1000_0204;
        rd(A_MASK, d); chk("R2 clear", d, m_en);
        wr(A_ENC, 32'h0);
        rd(A_MASK, d); chk("R2 zero clear", d, m_en);

        // level sweeps: all high level, priority 3*i mod 8, all enabled
        src_in = '0; settle();
        for (int i = 0; i < 32; i++) set_mode(i, 0, (i * 3) % 8);
        wr(A_ENS, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        check_irq("R5 idle");

        // walking single request: R7 index to vector
        for (int k = 0; k < 32; k++) begin
            src_in = 32'h1 << k; settle();
            check_irq("R5 level");
            do_ack("R7 walk");
            check_irq("R10 after ack");
            do_eoi();
        end

        // equal-priority pairs k and k+8: R7 tie goes to lower index
        for (int k = 0; k < 16; k++) begin
            src_in = (32'h1 << k) | (32'h1 << (k + 8)); settle();
            do_ack("R7 tie");
            check_irq("R10 tie level held");
            do_eoi();
        end

        // pseudo-random dense and sparse words
        lf = 32'h1ACE_B00C;
        for (int t = 0; t < 40; t++) begin
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            src_in = (t % 2 == 0) ? lf : (lf & (lf >> 7) & (lf << 3));
            if (t == 39) src_in = '0;
            settle();
            check_irq("R10 random");
            do_ack(t == 39 ? "R8 empty" : "R7 random");
            check_irq("R10 preempt strict");
            do_eoi();
            check_irq("R10 after pop");
        end
        src_in = '0; settle();

        // R5: low level on source 0 and external source 30
        wr(A_ENC, 32'hFFFF_FFFF); m_en = '0;
        src_in = (32'h1 << 0) | (32'h1 << 30);
        set_mode(0, 2, 3); set_mode(30, 2, 5);
        wr(A_ENS, 32'h4000_0001); m_en = 32'h4000_0001;
        settle(); check_irq("R5 low idle");
        src_in[0] = 1'b0; settle();
        check_irq("R5 low active");
        do_ack("R5 low vector");
        src_in[30] = 1'b0; settle();
        check_irq("R10 higher preempts");
        do_ack("R7 nested vector");
        do_eoi(); do_eoi();
        wr(A_ENC, 32'hFFFF_FFFF); m_en = '0;
        src_in = '0; settle();

        // R6 / R9: rising on source 5, falling on source 26
        set_mode(5, 1, 4); set_mode(26, 3, 2);
        wr(A_ENS, (32'h1 << 5)); m_en = 32'h1 << 5;
        pulse(32'h1 << 5);
        check_irq("R6 latch held");
        wr(A_ECLR, 32'h1 << 5); m_latch[5] = 1'b0;
        check_irq("R6 edge clear");
        pulse(32'h1 << 5);
        do_ack("R9 edge vector");
        do_eoi();
        check_irq("R9 latch cleared by ack");
        src_in[26] = 1'b1; settle();
        wr(A_ENS, 32'h1 << 26); m_en[26] = 1'b1;
        check_irq("R6 no fall yet");
        src_in[26] = 1'b0; settle(); m_latch[26] = 1'b1;
        check_irq("R6 falling latched");
        do_ack("R6 falling vector");
        do_eoi();
        check_irq("R9 falling cleared");

        // R10 / R11: priority ladder on sources 8..15 (priority = index-8)
        wr(A_ENC, 32'hFFFF_FFFF); m_en = '0;
        for (int p = 0; p < 8; p++) set_mode(8 + p, 1, p);
        wr(A_ENS, 32'h0000_FF00); m_en = 32'h0000_FF00;
        for (int p = 0; p < 8; p++) begin
            pulse(32'h1 << (8 + p));
            check_irq("R10 ladder raise");
            do_ack("R9 ladder ack");
            check_irq("R10 ladder quiet");
            if (p == 3) begin
                pulse(32'h1 << 10);
                check_irq("R10 lower waits");
                do_ack("R8 blocked read");
            end
        end
        chk("R11 full depth", 32'(sc), 32'd8);
        for (int n = 0; n < 8; n++) begin
            do_eoi();
            check_irq("R10 unwind strict");
        end
        do_ack("R9 reack");
        for (int n = 0; n < 8; n++) do_eoi();
        pulse(32'h1 << 8);
        check_irq("R11 eight pops empty");
        do_ack("R11 low after pops");
        do_eoi();
        do_eoi();
        check_irq("R10 pop on empty");

        // R12: disable all then clear all
        for (int i = 0; i < 32; i++) set_mode(i, 1, 1);
        wr(A_ENS, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        pulse(32'h8421_1248);
        check_irq("R12 pending before");
        wr(A_ENC, 32'hFFFF_FFFF); m_en = '0;
        wr(A_ECLR, 32'hFFFF_FFFF); m_latch = '0;
        rd(A_MASK, d); chk("R12 mask", d, 32'h0);
        check_irq("R12 irq low");
        do_ack("R12 spurious");
        wr(A_ENS, 32'hFFFF_FFFF); m_en = 32'hFFFF_FFFF;
        settle();
        check_irq("R12 no latch left");
        do_ack("R12 spurious after enable");

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule